// File: doc/BRIEF.md
# DRAM Access and Refresh Sequencer

This block produces the strobe and handshake timing for a single DRAM bank. It serves two sources that compete for the bank: a processor access request (active low) and a refresh-pending flag raised by a separate refresh tracker. Each source is sampled on its own clock edge. The request is sampled on rising edges and the refresh flag on falling edges. Whichever source is seen first takes the bank. The other source waits until the running cycle and its precharge interval have both finished.

An access cycle raises the grant and lowers the row strobe together. The column strobe follows one and a half cycles later. After four cycles the block drives the acknowledge low. If page mode is held, the row strobe stays low past the normal four-cycle pulse. A refresh cycle first switches the address mux to the refresh address. Half a cycle later it lowers the row strobe for four cycles and leaves the column strobe high. When that pulse ends, it sends a one-cycle done pulse to the tracker. Events on half-cycle boundaries come from falling-edge registers. The block does not include the address mux itself; it only drives the phase code that steers it.

Top module: `dram_seq`

## Requirements
- R1: A synchronous active-high reset sets ras_n and cas_n high, grant low, ack_oe low, ack_val high, mux_phase to row (0) and rfsh_done low. It treats precharge as already met, so an access can start on the first rising edge after reset.
- R2: After ras_n rises, it stays high for at least 4 cycles when pre_sel is 0 and at least 3 cycles when pre_sel is 1. A waiting access starts on the first rising edge at which that count is reached.
- R3: The refresh flag is sampled on falling edges and the request on rising edges, and the earlier sample wins. A loser that is still pending is served once the winner's cycle and precharge are complete.
- R4: An access raises grant and lowers ras_n on the same rising edge. grant is never high during a refresh cycle.
- R5: With page_n high, ras_n rises on the fourth rising edge after it fell.
- R6: If page_n is low and req_n is low at the edge that would end the four-cycle pulse, ras_n stays low. It rises at the first rising edge that samples page_n high or req_n high.
- R7: cas_n falls on the falling edge 1.5 cycles after ras_n falls, whatever row_hold_sel is. cas_n rises on the rising edge that samples req_n high.
- R8: mux_phase uses the codes row = 0, column = 1 and refresh = 2. It switches to column on the falling edge half a cycle after ras_n falls when row_hold_sel is 1, and on the rising edge one cycle after when row_hold_sel is 0.
- R9: ack_oe is high from the start of an access until the rising edge that samples req_n high. ack_val goes low on the fourth rising edge after ras_n falls. Once the access completes, all outputs hold until req_n is released.
- R10: For a refresh, mux_phase shows refresh from the accepting falling edge. ras_n falls on the next rising edge and rises 4 cycles later regardless of page_n, while cas_n stays high. rfsh_done is high for exactly the one cycle after the release edge.
- R11: A request made during a refresh is ignored until the refresh and its precharge are done. It then starts on the first rising edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges are used |
| rst | input | 1 | Synchronous reset, active high |
| req_n | input | 1 | Access request, active low |
| page_n | input | 1 | Page-mode select, active low |
| pre_sel | input | 1 | Precharge length: 0 selects 4 cycles, 1 selects 3 |
| row_hold_sel | input | 1 | Row-address hold: 0 selects one cycle, 1 selects half a cycle |
| rfsh_pend | input | 1 | Refresh pending flag from the refresh tracker |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| grant | output | 1 | Access granted, active high |
| ack_val | output | 1 | Acknowledge level (low means done) |
| ack_oe | output | 1 | Acknowledge output enable |
| mux_phase | output | 2 | Address select: 0 row, 1 column, 2 refresh |
| rfsh_done | output | 1 | One-cycle pulse at the end of a refresh |

## Verification
The bench approaches the precharge count from both sides for each length. It asks for an access one cycle early, which must be refused, and then exactly on time; a counter that is off by one either starts early or loses a cycle. It sets up both races between the two sources: a refresh flag that arrives half a cycle ahead of a request, and a refresh flag that arrives during an access. A design that samples both sources on the same edge, or that preempts a running access, would raise grant during a refresh or lower ras_n too early. It also holds page mode through a refresh, releases a request partway through a pulse, and ends a page-mode access both by lifting page_n and by lifting req_n. Each of these shows whether the row strobe is stretched, cut short or released at the correct edge.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

  // Sequencer state, advanced on rising edges.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_REF  = 2'd2
  } seq_st_t;

  // Address-mux phase code presented on mux_phase.
  typedef enum logic [1:0] {
    MUX_ROW = 2'd0,
    MUX_COL = 2'd1,
    MUX_REF = 2'd2
  } mux_t;

endpackage

// File: rtl/dseq_prech.sv
// Counts rising edges with the row strobe high and reports whether the
// selected minimum precharge interval has elapsed.
module dseq_prech #(
  parameter int PRE_LONG  = 4,
  parameter int PRE_SHORT = 3,
  parameter int PW        = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pre_sel,
  input  logic          ras_n,
  input  logic          ras_start,
  input  logic          ras_stop,
  output logic          pc_ok,
  output logic [PW-1:0] pc_cnt
);

  localparam logic [PW-1:0] LONG_T  = PW'(PRE_LONG);
  localparam logic [PW-1:0] SHORT_T = PW'(PRE_SHORT);
  localparam logic [PW-1:0] ONE_T   = PW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_cnt <= LONG_T;              // precharge counts as satisfied
    end else if (ras_stop) begin
      pc_cnt <= ONE_T;               // release edge is the first high cycle
    end else if (ras_start) begin
      pc_cnt <= '0;
    end else if (ras_n && (pc_cnt != LONG_T)) begin
      pc_cnt <= pc_cnt + ONE_T;
    end
  end

  assign pc_ok = (pc_cnt >= (pre_sel ? SHORT_T : LONG_T));

endmodule

// File: rtl/dseq_fall.sv
// Falling-edge registers: refresh acceptance, half-cycle column select and
// the column strobe that lands 1.5 cycles after the row strobe.
module dseq_fall
  import dseq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  seq_st_t st,
  input  logic    col_due,
  input  logic    pc_ok,
  input  logic    rfsh_pend,
  output logic    rf_arm,
  output logic    col_half,
  output logic    cas_q
);

  always_ff @(negedge clk) begin
    if (rst) begin
      rf_arm   <= 1'b0;
      col_half <= 1'b0;
      cas_q    <= 1'b0;
    end else begin
      rf_arm   <= (st == ST_IDLE) && pc_ok && rfsh_pend;
      col_half <= (st == ST_ACC);
      cas_q    <= (st == ST_ACC) && col_due;
    end
  end

endmodule

// File: rtl/dseq_core.sv
// Rising-edge sequencer: arbitration result, row strobe, grant and acknowledge.
module dseq_core
  import dseq_pkg::*;
#(
  parameter int RAS_CYC = 4,
  parameter int ACK_CYC = 4,
  parameter int TC_SAT  = 5,
  parameter int CW      = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_n,
  input  logic          page_n,
  input  logic          pc_ok,
  input  logic          rf_arm,
  output seq_st_t       st,
  output logic [CW-1:0] tcnt,
  output logic          ras_n,
  output logic          grant,
  output logic          ack_oe,
  output logic          ack_val,
  output logic          rfsh_done,
  output logic          ras_start,
  output logic          ras_stop
);

  localparam logic [CW-1:0] RAS_T = CW'(RAS_CYC);
  localparam logic [CW-1:0] ACK_T = CW'(ACK_CYC);
  localparam logic [CW-1:0] SAT_T = CW'(TC_SAT);
  localparam logic [CW-1:0] ONE_T = CW'(1);

  seq_st_t       st_nx;
  logic [CW-1:0] tc_nx;
  logic          ras_nx, gnt_nx, oe_nx, ack_nx, done_nx;

  always_comb begin
    st_nx     = st;
    tc_nx     = tcnt;
    ras_nx    = ras_n;
    gnt_nx    = grant;
    oe_nx     = ack_oe;
    ack_nx    = ack_val;
    done_nx   = 1'b0;
    ras_start = 1'b0;
    ras_stop  = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (rf_arm) begin
          // refresh was seen on the preceding falling edge: it wins
          st_nx     = ST_REF;
          ras_nx    = 1'b0;
          tc_nx     = ONE_T;
          ras_start = 1'b1;
        end else if (pc_ok && !req_n) begin
          st_nx     = ST_ACC;
          ras_nx    = 1'b0;
          gnt_nx    = 1'b1;
          oe_nx     = 1'b1;
          ack_nx    = 1'b1;
          tc_nx     = ONE_T;
          ras_start = 1'b1;
        end
      end
      ST_ACC: begin
        if (req_n) begin
          st_nx  = ST_IDLE;
          gnt_nx = 1'b0;
          oe_nx  = 1'b0;
          ack_nx = 1'b1;
          if (!ras_n) begin
            ras_nx   = 1'b1;
            ras_stop = 1'b1;
          end
        end else begin
          if (tcnt != SAT_T) tc_nx = tcnt + ONE_T;
          if (tcnt == ACK_T) ack_nx = 1'b0;
          if (!ras_n && (tcnt >= RAS_T) && page_n) begin
            ras_nx   = 1'b1;
            ras_stop = 1'b1;
          end
        end
      end
      ST_REF: begin
        if (tcnt != SAT_T) tc_nx = tcnt + ONE_T;
        if (tcnt == RAS_T) begin
          st_nx    = ST_IDLE;
          ras_nx   = 1'b1;
          ras_stop = 1'b1;
          done_nx  = 1'b1;
        end
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      tcnt      <= '0;
      ras_n     <= 1'b1;
      grant     <= 1'b0;
      ack_oe    <= 1'b0;
      ack_val   <= 1'b1;
      rfsh_done <= 1'b0;
    end else begin
      st        <= st_nx;
      tcnt      <= tc_nx;
      ras_n     <= ras_nx;
      grant     <= gnt_nx;
      ack_oe    <= oe_nx;
      ack_val   <= ack_nx;
      rfsh_done <= done_nx;
    end
  end

  // R4: grant stays low for the whole refresh
  a_r4_no_grant_in_refresh: assert property (@(posedge clk) disable iff (rst)
    (st == ST_REF) |-> !grant);

  // R5: while the request is held, the row strobe never ends before its pulse length
  a_r5_ras_min_width: assert property (@(posedge clk) disable iff (rst)
    ($rose(ras_n) && ($past(st) == ST_ACC) && !$past(req_n)) |-> ($past(tcnt) >= RAS_T));

  // R9: acknowledge is only driven low while enabled
  a_r9_ack_needs_enable: assert property (@(posedge clk) disable iff (rst)
    !ack_val |-> ack_oe);

  // R10: done is a single-cycle pulse
  a_r10_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
    rfsh_done |=> !rfsh_done);

endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dseq_pkg::*;
#(
  parameter int RAS_CYC   = 4,
  parameter int ACK_CYC   = 4,
  parameter int PRE_LONG  = 4,
  parameter int PRE_SHORT = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_n,
  input  logic       page_n,
  input  logic       pre_sel,
  input  logic       row_hold_sel,
  input  logic       rfsh_pend,
  output logic       ras_n,
  output logic       cas_n,
  output logic       grant,
  output logic       ack_val,
  output logic       ack_oe,
  output logic [1:0] mux_phase,
  output logic       rfsh_done
);

  localparam int TC_SAT = ((RAS_CYC > ACK_CYC) ? RAS_CYC : ACK_CYC) + 1;
  localparam int CW     = $clog2(TC_SAT + 1);
  localparam int PW     = $clog2(PRE_LONG + 1);
  // count value seen one full rising edge after the row strobe fell
  localparam logic [CW-1:0] COL_T = CW'(2);

  seq_st_t       st;
  logic [CW-1:0] tcnt;
  logic [PW-1:0] pc_cnt;
  logic          pc_ok, rf_arm, col_half, cas_q, col_due;
  logic          ras_start, ras_stop;

  assign col_due = (tcnt >= COL_T);

  dseq_core #(
    .RAS_CYC(RAS_CYC), .ACK_CYC(ACK_CYC), .TC_SAT(TC_SAT), .CW(CW)
  ) u_core (
    .clk(clk), .rst(rst), .req_n(req_n), .page_n(page_n),
    .pc_ok(pc_ok), .rf_arm(rf_arm), .st(st), .tcnt(tcnt),
    .ras_n(ras_n), .grant(grant), .ack_oe(ack_oe), .ack_val(ack_val),
    .rfsh_done(rfsh_done), .ras_start(ras_start), .ras_stop(ras_stop)
  );

  dseq_prech #(
    .PRE_LONG(PRE_LONG), .PRE_SHORT(PRE_SHORT), .PW(PW)
  ) u_prech (
    .clk(clk), .rst(rst), .pre_sel(pre_sel), .ras_n(ras_n),
    .ras_start(ras_start), .ras_stop(ras_stop),
    .pc_ok(pc_ok), .pc_cnt(pc_cnt)
  );

  dseq_fall u_fall (
    .clk(clk), .rst(rst), .st(st), .col_due(col_due), .pc_ok(pc_ok),
    .rfsh_pend(rfsh_pend), .rf_arm(rf_arm), .col_half(col_half), .cas_q(cas_q)
  );

  assign cas_n = !(cas_q && (st == ST_ACC));

  always_comb begin
    if ((st == ST_REF) || rf_arm)
      mux_phase = MUX_REF;
    else if ((st == ST_ACC) && (row_hold_sel ? col_half : col_due))
      mux_phase = MUX_COL;
    else
      mux_phase = MUX_ROW;
  end

  // R2: every row-strobe assertion follows a full precharge interval
  a_r2_precharge_met: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> ($past(pc_cnt) >= ($past(pre_sel) ? PW'(PRE_SHORT) : PW'(PRE_LONG))));

  // R10: the column strobe stays high during a refresh
  a_r10_no_cas_in_refresh: assert property (@(posedge clk) disable iff (rst)
    (st == ST_REF) |-> cas_n);

endmodule

// File: tb/test_dram_seq.sv
module test_dram_seq;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_n = 1'b1, page_n = 1'b1, pre_sel = 1'b0;
  logic       row_hold_sel = 1'b1, rfsh_pend = 1'b0;
  logic       ras_n, cas_n, grant, ack_val, ack_oe, rfsh_done;
  logic [1:0] mux_phase;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done_run = 1'b0;

  int          q_cyc[$];
  logic [7:0]  q_exp[$];
  string       q_tag[$];

  always #2.5 clk = ~clk;   // 200 MHz
  always @(posedge clk) cyc <= cyc + 1;

  dram_seq i_dram_seq (
    .clk(clk), .rst(rst), .req_n(req_n), .page_n(page_n), .pre_sel(pre_sel),
    .row_hold_sel(row_hold_sel), .rfsh_pend(rfsh_pend),
    .ras_n(ras_n), .cas_n(cas_n), .grant(grant), .ack_val(ack_val),
    .ack_oe(ack_oe), .mux_phase(mux_phase), .rfsh_done(rfsh_done)
  );

  // {ras_n, cas_n, grant, ack_oe, ack_val, mux_phase[1:0], rfsh_done}
  function automatic logic [7:0] V(input logic r, input logic c, input logic g,
                                   input logic oe, input logic a,
                                   input logic [1:0] m, input logic d);
    return {r, c, g, oe, a, m, d};
  endfunction

  localparam logic [7:0] ID = 8'b1100_1000;

  // Driver: apply inputs after an edge and queue the result for the next edge.
  task automatic step(input logic rq, input logic pg, input logic pend,
                      input logic [7:0] e, input string tag);
    @(posedge clk);
    #1;
    req_n = rq; page_n = pg; rfsh_pend = pend;
    q_cyc.push_back(cyc + 1);
    q_exp.push_back(e);
    q_tag.push_back(tag);
  endtask

  // Monitor: compare late in each cycle, after both edges have settled.
  initial begin
    forever begin
      @(posedge clk);
      #4;
      if (q_cyc.size() > 0 && q_cyc[0] == cyc) begin
        logic [7:0] got;
        logic [7:0] exp;
        string      tag;
        got = {ras_n, cas_n, grant, ack_oe, ack_val, mux_phase, rfsh_done};
        exp = q_exp.pop_front();
        tag = q_tag.pop_front();
        void'(q_cyc.pop_front());
        checks++;
        if (got !== exp) begin
          errors++;
          $display("FAIL %s cycle %0d got %b expected %b", tag, cyc, got, exp);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done_run) begin
      errors++;
      $display("FAIL R1 watchdog got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    step(1, 1, 0, ID, "R1");
    // access, half-cycle row hold, non-page
    step(0, 1, 0, V(0,1,1,1,1,2'd1,0), "R4");
    step(0, 1, 0, V(0,0,1,1,1,2'd1,0), "R7");
    step(0, 1, 0, V(0,0,1,1,1,2'd1,0), "R8");
    step(0, 1, 0, V(0,0,1,1,1,2'd1,0), "R9");
    step(0, 1, 0, V(1,0,1,1,0,2'd1,0), "R5");
    step(0, 1, 0, V(1,0,1,1,0,2'd1,0), "R9");
    step(1, 1, 0, ID, "R9");
    // 4-cycle precharge: one edge early is refused
    row_hold_sel = 1'b0;
    step(0, 1, 0, ID, "R2");
    step(0, 1, 0, V(0,1,1,1,1,2'd0,0), "R2");
    step(0, 1, 0, V(0,0,1,1,1,2'd1,0), "R8");
    step(0, 1, 0, V(0,0,1,1,1,2'd1,0), "R7");
    step(0, 1, 0, V(0,0,1,1,1,2'd1,0), "R7");
    step(0, 0, 0, V(0,0,1,1,0,2'd1,0), "R6");
    step(0, 0, 0, V(0,0,1,1,0,2'd1,0), "R6");
    step(0, 1, 0, V(1,0,1,1,0,2'd1,0), "R6");
    step(1, 1, 0, ID, "R9");
    // 3-cycle precharge, then page mode ended by the request
    pre_sel = 1'b1;
    step(0, 1, 0, ID, "R2");
    step(0, 1, 0, V(0,1,1,1,1,2'd0,0), "R2");
    step(0, 0, 0, V(0,0,1,1,1,2'd1,0), "R7");
    step(0, 0, 0, V(0,0,1,1,1,2'd1,0), "R7");
    step(0, 0, 0, V(0,0,1,1,1,2'd1,0), "R7");
    step(0, 0, 0, V(0,0,1,1,0,2'd1,0), "R6");
    step(1, 0, 0, ID, "R6");
    // refresh with a request arriving during it
    pre_sel = 1'b0;
    step(1, 1, 1, ID, "R3");
    step(1, 1, 1, ID, "R3");
    step(1, 1, 1, V(1,1,0,0,1,2'd2,0), "R10");
    step(1, 1, 1, V(0,1,0,0,1,2'd2,0), "R10");
    step(0, 1, 1, V(0,1,0,0,1,2'd2,0), "R11");
    step(0, 1, 1, V(0,1,0,0,1,2'd2,0), "R11");
    step(0, 1, 1, V(0,1,0,0,1,2'd2,0), "R11");
    step(0, 1, 0, V(1,1,0,0,1,2'd0,1), "R10");
    step(0, 1, 0, ID, "R11");
    step(0, 1, 0, ID, "R11");
    step(0, 1, 0, ID, "R11");
    step(0, 1, 0, V(0,1,1,1,1,2'd0,0), "R11");
    step(1, 1, 0, ID, "R7");
    // both sources at once: refresh is sampled first
    pre_sel = 1'b1;
    step(0, 1, 1, ID, "R3");
    step(0, 1, 1, V(1,1,0,0,1,2'd2,0), "R3");
    step(0, 1, 1, V(0,1,0,0,1,2'd2,0), "R3");
    step(0, 1, 0, V(0,1,0,0,1,2'd2,0), "R4");
    step(0, 1, 0, V(0,1,0,0,1,2'd2,0), "R4");
    step(0, 1, 0, V(0,1,0,0,1,2'd2,0), "R10");
    step(0, 1, 0, V(1,1,0,0,1,2'd0,1), "R10");
    step(0, 1, 0, ID, "R3");
    step(0, 1, 0, ID, "R3");
    step(0, 1, 0, V(0,1,1,1,1,2'd0,0), "R3");
    // refresh raised during an access waits for it
    step(0, 1, 1, V(0,0,1,1,1,2'd1,0), "R3");
    step(0, 1, 1, V(0,0,1,1,1,2'd1,0), "R3");
    step(0, 1, 1, V(0,0,1,1,1,2'd1,0), "R3");
    step(0, 1, 1, V(1,0,1,1,0,2'd1,0), "R5");
    step(1, 1, 1, ID, "R3");
    step(1, 1, 1, V(1,1,0,0,1,2'd2,0), "R3");
    step(1, 0, 1, V(0,1,0,0,1,2'd2,0), "R2");
    step(1, 0, 0, V(0,1,0,0,1,2'd2,0), "R10");
    step(1, 0, 0, V(0,1,0,0,1,2'd2,0), "R10");
    step(1, 0, 0, V(0,1,0,0,1,2'd2,0), "R10");
    step(1, 0, 0, V(1,1,0,0,1,2'd0,1), "R10");
    step(1, 1, 0, ID, "R10");

    repeat (2) @(posedge clk);
    #4;
    if (q_cyc.size() != 0) begin
      errors++;
      $display("FAIL R1 pending checks got %0d expected 0", q_cyc.size());
    end
    done_run = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule